// File: doc/BRIEF.md
# Synchronous Three-Port Register File with Write Forwarding

This block holds the architected integer and floating-point registers of an in-order core: 32 of each, 64 entries in one array. It has three read ports and one write port. The array is read synchronously so that it can map onto block RAM. The decode stage sends the three read addresses one cycle before the operands are needed. The addresses always come as a set of three, even when the instruction uses fewer.

The block registers the addresses it reads in each cycle. While the pipeline is stalled, it reads those registered addresses again and ignores the new ones. A write is applied to the array and also held for one cycle. Each read port compares its registered address with the held write address, and on a match it returns the held write data. This makes a read and a write to the same register in the same cycle behave as write-before-read.

A debugger can read any register through a request/acknowledge handshake. The debug read uses read port B, but only in a cycle where the pipeline is not stalled and port B is free. Port B is free when there is no valid instruction, or when the instruction does not use its second operand. The request stays pending until such a cycle comes.

Top module: `regfile_sync`

## Requirements
- R1: The array holds 64 entries addressed by a 6-bit physical index {bank, reg[4:0]}, where bank 1 selects the floating-point half. A write presented with `wrEn` high stores `wrData` at `wrAddr`, and later reads of that index return it.
- R2: Each read port returns data in the cycle after its address is presented. The data includes every write presented up to and including the cycle in which the address was presented.
- R3: While `stall` is high, the presented read addresses are ignored. Each port reads its previously registered address again, and the returned data still reflects writes made during the stall.
- R4: When a read address presented in cycle t equals the write address presented in cycle t, the port returns the new write data in cycle t+1.
- R5: A debug read takes port B only in a cycle where `stall` is low and not both `instrValid` and `usesB` are high. Otherwise the request waits, and `dbgAck` stays low.
- R6: `dbgAck` is a single-cycle pulse in the cycle after the slot is taken. No second slot is taken during the acknowledge cycle.
- R7: The debug index is 7 bits. Bit 6 selects the floating-point bank and bits 4:0 give the register number. When bit 5 is set, the index names no entry, and the request is acknowledged with `dbgData` equal to zero. Otherwise `dbgData` carries the register value, including a write presented in the slot cycle.
- R8: After reset, `dbgAck` is low and no debug request is pending.
- R9: A debug read leaves the data returned on ports A and C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | The decode stage presents a valid instruction |
| usesB | input | 1 | That instruction uses its second operand |
| stall | input | 1 | Pipeline stall: keep the registered read addresses |
| rdAddrA | input | 6 | Physical read index, port A |
| rdAddrB | input | 6 | Physical read index, port B |
| rdAddrC | input | 6 | Physical read index, port C |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 6 | Physical write index |
| wrData | input | 64 | Write data |
| dbgReq | input | 1 | Debug read request, held until acknowledged |
| dbgIdx | input | 7 | Debug register index |
| rdDataA | output | 64 | Read data, port A |
| rdDataB | output | 64 | Read data, port B |
| rdDataC | output | 64 | Read data, port C |
| dbgAck | output | 1 | Debug read done; `dbgData` is valid |
| dbgData | output | 64 | Debug read data |

## Verification
The assertions check on every cycle that:
- a same-cycle write to the address read on port A is forwarded in the next cycle;
- the registered addresses stay fixed through a stall;
- the debug slot is never taken while port B is busy or the pipeline is stalled;
- every slot is followed by exactly one acknowledge pulse;
- a request for an unmapped index returns zero.

Only the bench scenarios can show that the stored contents are right across the whole array. They also show that reads during a stall see writes made during the stall, that debug reads return the right register from either bank, and that ports A and C are undisturbed while a debug read is in progress.

// File: rtl/rfile_pkg.sv
package rfile_pkg;
  // Strobes from control to the datapath
  typedef struct packed {
    logic dbgSlot;   // port B serves the debug request this cycle
    logic holdAddr;  // reuse the registered read addresses
    logic zeroDbg;   // the debug read being acknowledged hit an unmapped index
  } rf_strobe_t;

  localparam int NUM_RD = 3;
  localparam int PORT_B = 1;
endpackage

// File: rtl/rfile_ctrl.sv
module rfile_ctrl
  import rfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       instrValid,
  input  logic       usesB,
  input  logic       stall,
  input  logic       dbgReq,
  input  logic       dbgHoleReq,
  output rf_strobe_t strobes,
  output logic       dbgAck
);
  logic ackQ, holeQ, slotFree;

  // R5: port B is free only when it is not needed and addresses are not held
  assign slotFree = !stall && !(instrValid && usesB);

  always_comb begin
    strobes.dbgSlot  = dbgReq && !ackQ && slotFree;   // R6: no slot in the ack cycle
    strobes.holdAddr = stall;
    strobes.zeroDbg  = holeQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ  <= 1'b0;                                  // R8
      holeQ <= 1'b0;
    end else begin
      ackQ  <= strobes.dbgSlot;
      holeQ <= strobes.dbgSlot && dbgHoleReq;
    end
  end

  assign dbgAck = ackQ;
endmodule

// File: rtl/rfile_datapath.sv
module rfile_datapath
  import rfile_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int DATA_W   = 64,
  localparam int PHYS_W  = REG_BITS + 1,
  localparam int ENTRIES = 1 << PHYS_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  rf_strobe_t                         strobes,
  input  logic [NUM_RD-1:0][PHYS_W-1:0]      rdAddr,
  input  logic [PHYS_W-1:0]                  dbgPhys,
  input  logic                               wrEn,
  input  logic [PHYS_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                  wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0]      rdData,
  output logic [NUM_RD-1:0][PHYS_W-1:0]      curAddr,
  output logic [DATA_W-1:0]                  dbgData
);
  logic [DATA_W-1:0] mem [ENTRIES];
  logic              wrValidQ;
  logic [PHYS_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;

  // R1: single write port into the array
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Held copy of the last write, used for forwarding (R4)
  always_ff @(posedge clk) begin
    if (rst) begin
      wrValidQ <= 1'b0;
      wrAddrQ  <= '0;
      wrDataQ  <= '0;
    end else begin
      wrValidQ <= wrEn;
      wrAddrQ  <= wrAddr;
      wrDataQ  <= wrData;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic [PHYS_W-1:0] addrSel, addrQ;
    logic [DATA_W-1:0] ramQ;

    if (p == PORT_B) begin : g_dbg
      always_comb begin
        if (strobes.holdAddr)     addrSel = addrQ;      // R3
        else if (strobes.dbgSlot) addrSel = dbgPhys;    // R5
        else                      addrSel = rdAddr[p];
      end
    end else begin : g_plain
      always_comb addrSel = strobes.holdAddr ? addrQ : rdAddr[p];  // R3
    end

    // R2: synchronous read, array returns pre-write contents
    always_ff @(posedge clk) ramQ <= mem[addrSel];

    always_ff @(posedge clk) begin
      if (rst) addrQ <= '0;
      else     addrQ <= addrSel;
    end

    // R4: same-address write of the previous edge overrides the array output
    assign rdData[p]  = (wrValidQ && (wrAddrQ == addrQ)) ? wrDataQ : ramQ;
    assign curAddr[p] = addrQ;
  end

  // R7: unmapped debug indices read as zero
  assign dbgData = strobes.zeroDbg ? '0 : rdData[PORT_B];
endmodule

// File: rtl/regfile_sync.sv
module regfile_sync
  import rfile_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int DATA_W   = 64,
  localparam int PHYS_W  = REG_BITS + 1,
  localparam int IDX_W   = REG_BITS + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic              usesB,
  input  logic              stall,
  input  logic [PHYS_W-1:0] rdAddrA,
  input  logic [PHYS_W-1:0] rdAddrB,
  input  logic [PHYS_W-1:0] rdAddrC,
  input  logic              wrEn,
  input  logic [PHYS_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dbgReq,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] rdDataC,
  output logic              dbgAck,
  output logic [DATA_W-1:0] dbgData
);
  rf_strobe_t                      strobes;
  logic [NUM_RD-1:0][PHYS_W-1:0]   rdAddr, curAddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdData;
  logic [PHYS_W-1:0]               dbgPhys;

  assign rdAddr  = {rdAddrC, rdAddrB, rdAddrA};
  // R7: top index bit selects the bank, the bit below it marks a hole
  assign dbgPhys = {dbgIdx[IDX_W-1], dbgIdx[REG_BITS-1:0]};

  rfile_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .usesB      (usesB),
    .stall      (stall),
    .dbgReq     (dbgReq),
    .dbgHoleReq (dbgIdx[IDX_W-2]),
    .strobes    (strobes),
    .dbgAck     (dbgAck)
  );

  rfile_datapath #(.REG_BITS(REG_BITS), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rdAddr  (rdAddr),
    .dbgPhys (dbgPhys),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .curAddr (curAddr),
    .dbgData (dbgData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
  assign rdDataC = rdData[2];
endmodule

// File: rtl/rfile_checker.sv
module rfile_checker
  import rfile_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter int DATA_W   = 64,
  localparam int PHYS_W  = REG_BITS + 1
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          stall,
  input logic                          instrValid,
  input logic                          usesB,
  input logic                          wrEn,
  input logic [PHYS_W-1:0]             wrAddr,
  input logic [DATA_W-1:0]             wrData,
  input logic [PHYS_W-1:0]             rdAddrA,
  input logic [DATA_W-1:0]             rdDataA,
  input logic                          dbgHole,
  input logic                          dbgAck,
  input logic [DATA_W-1:0]             dbgData,
  input rf_strobe_t                    strobes,
  input logic [NUM_RD-1:0][PHYS_W-1:0] curAddr
);
  AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !stall && (rdAddrA == wrAddr)) |=> (rdDataA == $past(wrData))); // R4

  AST_STALL_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    strobes.holdAddr |=> $stable(curAddr)); // R3

  AST_SLOT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (instrValid && usesB) |-> !strobes.dbgSlot); // R5

  AST_SLOT_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
    stall |-> !strobes.dbgSlot); // R5

  AST_ACK_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
    strobes.dbgSlot |=> dbgAck); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dbgAck |=> !dbgAck); // R6

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobes.dbgSlot && dbgHole) |=> (dbgData == '0)); // R7
endmodule

bind regfile_sync rfile_checker #(.REG_BITS(REG_BITS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .instrValid (instrValid),
  .usesB      (usesB),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .rdAddrA    (rdAddrA),
  .rdDataA    (rdDataA),
  .dbgHole    (dbgIdx[REG_BITS]),
  .dbgAck     (dbgAck),
  .dbgData    (dbgData),
  .strobes    (strobes),
  .curAddr    (curAddr)
);

// File: tb/tb_regfile_sync.sv
module tb_regfile_sync;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0, usesB = 1'b0, stall = 1'b0;
  logic [5:0]  rdA = '0, rdB = '0, rdC = '0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic        dbgReq = 1'b0;
  logic [6:0]  dbgIdx = '0;
  logic [63:0] rdDataA, rdDataB, rdDataC, dbgData;
  logic        dbgAck;

  always #(CLK_P/2) clk = ~clk;

  regfile_sync dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .usesB(usesB), .stall(stall),
    .rdAddrA(rdA), .rdAddrB(rdB), .rdAddrC(rdC),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgReq(dbgReq), .dbgIdx(dbgIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdDataC(rdDataC),
    .dbgAck(dbgAck), .dbgData(dbgData)
  );

  int          tests = 0, fails = 0;
  bit          finished = 1'b0;
  logic [63:0] model [64];
  logic [5:0]  hA = '0, hB = '0, hC = '0, ackPhys = '0;
  bit          ackNow = 1'b0, holeNow = 1'b0, cmpOn = 1'b0;
  string       tagAC = "R2", tagB = "R2";

  function automatic logic [63:0] pat(int a, int g);
    return {32'(a) * 32'h0100_0193 + 32'(g) * 32'h9E37_79B1, 32'(g) << 8 | 32'(a)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs are already set; model the edge, then compare at negedge
  task automatic step();
    bit         g;
    logic [5:0] dphys;
    dphys = {dbgIdx[6], dbgIdx[4:0]};
    g = dbgReq && !ackNow && !stall && !(instrValid && usesB);
    @(posedge clk);
    if (wrEn) model[wrAddr] = wrData;
    if (!stall) begin
      hA = rdA; hB = g ? dphys : rdB; hC = rdC;
    end
    ackNow = g; holeNow = dbgIdx[5]; ackPhys = dphys;
    @(negedge clk);
    if (cmpOn) begin
      chk(rdDataA === model[hA], tagAC, rdDataA, model[hA]);
      chk(rdDataB === model[hB], tagB,  rdDataB, model[hB]);
      chk(rdDataC === model[hC], tagAC, rdDataC, model[hC]);
    end
    chk(dbgAck === ackNow, "R6", {63'd0, dbgAck}, {63'd0, ackNow});
    if (ackNow) begin
      chk(dbgData === (holeNow ? 64'd0 : model[ackPhys]), "R7", dbgData,
          holeNow ? 64'd0 : model[ackPhys]);
      dbgReq = 1'b0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dbgAck === 1'b0, "R8", {63'd0, dbgAck}, 64'd0);

    // Fill every entry (R1)
    for (int i = 0; i < 64; i++) begin
      wrEn = 1'b1; wrAddr = 6'(i); wrData = pat(i, 1); step();
    end
    wrEn = 1'b0;

    // Full read sweep with concurrent writes elsewhere (R1, R2)
    cmpOn = 1'b1; tagAC = "R1"; tagB = "R1";
    for (int i = 0; i < 64; i++) begin
      rdA = 6'(i); rdB = 6'(63 - i); rdC = 6'((i * 5) % 64);
      wrEn = (i % 2 == 0); wrAddr = 6'((i * 3 + 1) % 64); wrData = pat(i, 2);
      step();
    end
    tagAC = "R2"; tagB = "R2";
    for (int i = 0; i < 64; i++) begin
      rdA = 6'((i * 3 + 1) % 64); rdB = 6'(i); rdC = 6'(i ^ 32);
      wrEn = 1'b0; step();
    end

    // Same-cycle write and read to one address on all ports (R4)
    tagAC = "R4"; tagB = "R4";
    for (int i = 0; i < 64; i++) begin
      wrEn = 1'b1; wrAddr = 6'(i); wrData = pat(i, 3);
      rdA = 6'(i); rdB = 6'(i); rdC = 6'(i ^ 32);
      step();
    end
    wrEn = 1'b0;

    // Stall holds the addresses; writes during stall are seen (R3)
    tagAC = "R3"; tagB = "R3";
    for (int k = 0; k < 8; k++) begin
      stall = 1'b0; rdA = 6'(k + 3); rdB = 6'(k + 40); rdC = 6'(k + 20); step();
      stall = 1'b1; rdA = 6'(k + 50); rdB = 6'(k); rdC = 6'(k + 9);
      wrEn = 1'b1; wrAddr = 6'(k + 3); wrData = pat(k, 4); step();
      wrAddr = 6'(k + 40); wrData = pat(k, 5); step();
      wrEn = 1'b0; step();
      stall = 1'b0; step();
    end

    // Request blocked while port B is in use or stalled (R5)
    tagAC = "R9"; tagB = "R5";
    dbgReq = 1'b1; dbgIdx = 7'h05; instrValid = 1'b1; usesB = 1'b1;
    for (int k = 0; k < 6; k++) begin
      stall = (k >= 3); usesB = (k < 3);
      step();
      chk(dbgAck === 1'b0, "R5", {63'd0, dbgAck}, 64'd0);
    end
    stall = 1'b0; usesB = 1'b0; step(); step();

    // Every debug index, varied free-slot reasons and same-cycle writes (R7, R9)
    tagB = "R7";
    for (int k = 0; k < 128; k++) begin
      dbgReq = 1'b1; dbgIdx = 7'(k);
      instrValid = (k % 3 != 0); usesB = 1'b0; stall = (k % 4 == 1);
      rdA = 6'(k % 64); rdC = 6'((k * 7) % 64); rdB = 6'((k + 11) % 64);
      wrEn = (k % 2 == 1); wrAddr = {dbgIdx[6], dbgIdx[4:0]}; wrData = pat(k, 6);
      for (int w = 0; w < 6 && !ackNow; w++) begin
        step();
        stall = 1'b0; wrEn = 1'b0;
      end
      chk(ackNow, "R6", {63'd0, ackNow}, 64'd1);
      step();
    end

    summary();
  end
endmodule